// File: doc/BRIEF.md
# Clock-Synchronous Serial Receiver with Buffer Flow Control

This block receives 8-bit words over a clock-synchronous serial link and stores them in a small receive queue that the CPU drains one word at a time. The block can act as the clock master, generating the serial clock itself, or as a slave that follows an external serial clock. The CPU reads the oldest stored word through a show-ahead read port. A fill-level interrupt flag rises when a newly stored word brings the queue to a programmable threshold.

An optional back-pressure mode stops the remote side while the queue is full, so that no word is lost. In slave role the block raises its active-low ready output. In master role it stops issuing serial clock pulses, whatever the remote ready input says, until the CPU frees a slot. The back-pressure bit and the threshold field belong to a protected configuration group. A write updates them only when the advanced-access input is asserted during that write. The role bit can always be written. An overrun flag records any word that arrives while the queue is full and has to be discarded.

Top module: `sync_rx_flow`

## Requirements
- R1: After reset, fillCount is 0, intFlag, overrun, rdyNOut and sclkOut are 0, the role is slave, back-pressure is off and the threshold code is 0.
- R2: Each word has 8 bits and is assembled MSB first from sdIn, sampled on rising serial clock edges. In slave role the edge comes from sclkIn. Completed words are stored in arrival order, and rdData always shows the oldest stored word.
- R3: A cycle with rdEn high and a non-empty queue removes the oldest word and lowers fillCount by one. rdEn on an empty queue changes nothing. fillCount never exceeds 4.
- R4: The threshold is the 2-bit code cfgLevel plus one (code 0 gives 1 word, code 3 gives 4 words). intFlag is set when a word is stored and the new fill count equals the threshold.
- R5: A cycle with clrWe high clears intFlag when clrBits bit 0 is 1 and clears overrun when clrBits bit 1 is 1.
- R6: With back-pressure off, rdyNOut stays 0 even when the queue is full. A word that completes on a full queue with no read in the same cycle is discarded and sets overrun.
- R7: With back-pressure on in slave role, rdyNOut is 1 exactly while the queue holds 4 words. It returns to 0 after a read that frees a slot.
- R8: In master role the block drives sclkOut with high and low phases of HALF clock cycles each. It starts a new word only while rdyNIn is low.
- R9: With back-pressure on in master role and a full queue, sclkOut stays low even when rdyNIn is low. Clocking resumes after a read.
- R10: A cfgWe write always updates the role bit (cfgMaster). It updates the back-pressure bit and the threshold code only when cfgAdv is 1; otherwise those two keep their previous values.
- R11: While the queue is not full, enabling back-pressure does not affect reception, and rdyNOut stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| cfgWe | input | 1 | Configuration write strobe |
| cfgAdv | input | 1 | Advanced access enable for protected fields |
| cfgMaster | input | 1 | Role bit: 1 master, 0 slave |
| cfgHiMask | input | 1 | Back-pressure enable (protected) |
| cfgLevel | input | 2 | Threshold code (protected) |
| clrWe | input | 1 | Flag clear strobe |
| clrBits | input | 2 | Bit 0 clears intFlag, bit 1 clears overrun |
| sclkIn | input | 1 | Serial clock from the remote master (slave role) |
| sdIn | input | 1 | Serial data |
| rdyNIn | input | 1 | Active-low ready from the remote slave (master role) |
| sclkOut | output | 1 | Generated serial clock (master role) |
| rdyNOut | output | 1 | Active-low ready to the remote master (slave role) |
| rdEn | input | 1 | CPU read/pop strobe |
| rdData | output | 8 | Oldest stored word |
| fillCount | output | 3 | Number of stored words |
| intFlag | output | 1 | Threshold interrupt flag |
| overrun | output | 1 | Lost-word flag |

## Verification
In slave role, a rising edge on sclkIn is detected against a registered copy of that input. The word therefore lands in the queue on the first clock edge after sclkIn goes high. fillCount, intFlag, overrun and rdyNOut all reflect the new word one edge after the final bit. In master role, the sampling edge is the same clock edge on which sclkOut rises. A read or a flag clear takes effect on the edge that samples the strobe. The bench drives every input just after a falling clock edge and reads results at a later falling edge. It also waits at least one full bit period after the last serial edge, and lets a whole phase pass before judging whether sclkOut has stayed low.

// File: rtl/sync_rx_pkg.sv
package sync_rx_pkg;
  // strobes from the control block to the datapath
  typedef struct packed {
    logic sample;    // shift sdIn into the assembly register this cycle
    logic wordDone;  // this sample is the last bit of a word
  } rxStrobes_t;
endpackage

// File: rtl/sync_rx_cfg.sv
module sync_rx_cfg #(
  parameter int LW = 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cfgWe,
  input  logic          cfgAdv,
  input  logic          cfgMaster,
  input  logic          cfgHiMask,
  input  logic [LW-1:0] cfgLevel,
  output logic          isMaster,
  output logic          hiMask,
  output logic [LW-1:0] level
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isMaster <= 1'b0;
      hiMask   <= 1'b0;
      level    <= '0;
    end else if (cfgWe) begin
      isMaster <= cfgMaster;
      if (cfgAdv) begin
        hiMask <= cfgHiMask;
        level  <= cfgLevel;
      end
    end
  end
endmodule

// File: rtl/sync_rx_ctrl.sv
module sync_rx_ctrl
  import sync_rx_pkg::*;
#(
  parameter int WORD = 8,
  parameter int HALF = 4
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       isMaster,
  input  logic       hiMask,
  input  logic       full,
  input  logic       sclkIn,
  input  logic       rdyNIn,
  output logic       sclkOut,
  output logic       rdyNOut,
  output rxStrobes_t strobes
);
  localparam int BW = $clog2(WORD);
  localparam int HW = $clog2(HALF);

  logic [BW-1:0] bitCnt;
  logic [HW-1:0] phaseCnt;
  logic          sclkPrev;
  logic          halfDone;
  logic          canRise;
  logic          sampleM;
  logic          sampleS;

  assign halfDone = (phaseCnt == HW'(HALF - 1));
  // back-pressure overrides the remote ready; ready only gates a word start
  assign canRise  = !(hiMask && full) && ((bitCnt != '0) || !rdyNIn);
  assign sampleM  = isMaster && halfDone && !sclkOut && canRise;
  assign sampleS  = !isMaster && sclkIn && !sclkPrev;

  assign strobes.sample   = sampleM || sampleS;
  assign strobes.wordDone = strobes.sample && (bitCnt == BW'(WORD - 1));
  assign rdyNOut          = !isMaster && hiMask && full;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkPrev <= 1'b0;
      bitCnt   <= '0;
    end else begin
      sclkPrev <= sclkIn;
      if (strobes.sample)
        bitCnt <= strobes.wordDone ? '0 : bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkOut  <= 1'b0;
      phaseCnt <= '0;
    end else if (!isMaster) begin
      sclkOut  <= 1'b0;
      phaseCnt <= '0;
    end else if (!halfDone) begin
      phaseCnt <= phaseCnt + 1'b1;
    end else if (sclkOut) begin
      sclkOut  <= 1'b0;
      phaseCnt <= '0;
    end else if (canRise) begin
      sclkOut  <= 1'b1;
      phaseCnt <= '0;
    end
  end
endmodule

// File: rtl/sync_rx_data.sv
module sync_rx_data
  import sync_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WORD  = 8,
  parameter int LW    = 2,
  parameter int CW    = 3
) (
  input  logic            clk,
  input  logic            rstN,
  input  rxStrobes_t      strobes,
  input  logic            sdIn,
  input  logic            rdEn,
  input  logic            clrWe,
  input  logic [1:0]      clrBits,
  input  logic [LW-1:0]   level,
  output logic [WORD-1:0] rdData,
  output logic [CW-1:0]   fillCount,
  output logic            full,
  output logic            intFlag,
  output logic            overrun
);
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WORD-1:0] mem [DEPTH];
  logic [WORD-1:0] shiftReg;
  logic [WORD-1:0] newWord;
  logic [PW-1:0]   rdPtr;
  logic [PW-1:0]   wrPtr;
  logic [CW-1:0]   nextCount;
  logic [CW-1:0]   thr;
  logic            pop;
  logic            push;
  logic            drop;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full      = (fillCount == CW'(DEPTH));
  assign pop       = rdEn && (fillCount != '0);
  assign newWord   = {shiftReg[WORD-2:0], sdIn};
  assign push      = strobes.wordDone && (!full || pop);
  assign drop      = strobes.wordDone && full && !pop;
  assign nextCount = fillCount + CW'(push) - CW'(pop);
  assign thr       = CW'(level) + CW'(1);
  assign rdData    = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (push) mem[wrPtr] <= newWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      rdPtr     <= '0;
      wrPtr     <= '0;
      fillCount <= '0;
      intFlag   <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (strobes.sample) shiftReg <= newWord;
      if (push) wrPtr <= bump(wrPtr);
      if (pop)  rdPtr <= bump(rdPtr);
      fillCount <= nextCount;
      if (push && (nextCount == thr))    intFlag <= 1'b1;
      else if (clrWe && clrBits[0])      intFlag <= 1'b0;
      if (drop)                          overrun <= 1'b1;
      else if (clrWe && clrBits[1])      overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/sync_rx_flow.sv
module sync_rx_flow
  import sync_rx_pkg::*;
#(
  parameter int DEPTH = 4,
  parameter int WORD  = 8,
  parameter int HALF  = 4,
  localparam int LW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cfgWe,
  input  logic            cfgAdv,
  input  logic            cfgMaster,
  input  logic            cfgHiMask,
  input  logic [LW-1:0]   cfgLevel,
  input  logic            clrWe,
  input  logic [1:0]      clrBits,
  input  logic            sclkIn,
  input  logic            sdIn,
  input  logic            rdyNIn,
  output logic            sclkOut,
  output logic            rdyNOut,
  input  logic            rdEn,
  output logic [WORD-1:0] rdData,
  output logic [CW-1:0]   fillCount,
  output logic            intFlag,
  output logic            overrun
);
  logic          isMaster;
  logic          hiMask;
  logic [LW-1:0] level;
  logic          full;
  logic          wordDone;
  rxStrobes_t    strobes;

  assign wordDone = strobes.wordDone;

  sync_rx_cfg #(.LW(LW)) u_cfg (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAdv(cfgAdv),
    .cfgMaster(cfgMaster), .cfgHiMask(cfgHiMask), .cfgLevel(cfgLevel),
    .isMaster(isMaster), .hiMask(hiMask), .level(level)
  );

  sync_rx_ctrl #(.WORD(WORD), .HALF(HALF)) u_ctrl (
    .clk(clk), .rstN(rstN), .isMaster(isMaster), .hiMask(hiMask),
    .full(full), .sclkIn(sclkIn), .rdyNIn(rdyNIn),
    .sclkOut(sclkOut), .rdyNOut(rdyNOut), .strobes(strobes)
  );

  sync_rx_data #(.DEPTH(DEPTH), .WORD(WORD), .LW(LW), .CW(CW)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes), .sdIn(sdIn), .rdEn(rdEn),
    .clrWe(clrWe), .clrBits(clrBits), .level(level), .rdData(rdData),
    .fillCount(fillCount), .full(full), .intFlag(intFlag), .overrun(overrun)
  );
endmodule

// File: rtl/sync_rx_flow_chk.sv
module sync_rx_flow_chk #(
  parameter int DEPTH = 4,
  parameter int CW    = 3
) (
  input logic          clk,
  input logic          rstN,
  input logic          isMaster,
  input logic          hiMask,
  input logic          full,
  input logic          sclkOut,
  input logic          rdyNOut,
  input logic          rdEn,
  input logic [CW-1:0] fillCount,
  input logic          overrun,
  input logic          wordDone
);
  // R3: occupancy bound
  p_fill_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));

  // R3: a read without a simultaneous arrival lowers the count by one
  p_pop_dec_r3: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && fillCount != '0 && !wordDone) |=> (fillCount == $past(fillCount) - 1'b1));

  // R6: ready output never asserted without back-pressure
  p_ready_idle_r6: assert property (@(posedge clk) disable iff (!rstN)
    !hiMask |-> !rdyNOut);

  // R6: a word lost on a full queue raises the overrun flag
  p_overrun_r6: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && full && !rdEn) |=> overrun);

  // R7: a read frees the slave-side hold on the next cycle
  p_ready_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (rdyNOut && rdEn && !wordDone) |=> !rdyNOut);

  // R9: master holds the serial clock low while back-pressured
  p_master_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && hiMask && full && !sclkOut) |=> !sclkOut);
endmodule

bind sync_rx_flow sync_rx_flow_chk #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .isMaster(isMaster), .hiMask(hiMask),
  .full(full), .sclkOut(sclkOut), .rdyNOut(rdyNOut), .rdEn(rdEn),
  .fillCount(fillCount), .overrun(overrun), .wordDone(wordDone)
);

// File: tb/sync_rx_flow_test.sv
module sync_rx_flow_test;
  localparam int HALF = 4;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       cfgWe = 1'b0, cfgAdv = 1'b0, cfgMaster = 1'b0, cfgHiMask = 1'b0;
  logic [1:0] cfgLevel = 2'd0;
  logic       clrWe = 1'b0;
  logic [1:0] clrBits = 2'd0;
  logic       sclkIn = 1'b0, sdIn = 1'b0, rdyNIn = 1'b0, rdEn = 1'b0;
  logic       sclkOut, rdyNOut, intFlag, overrun;
  logic [7:0] rdData;
  logic [2:0] fillCount;

  int checks = 0;
  int errors = 0;

  sync_rx_flow #(.DEPTH(4), .WORD(8), .HALF(HALF)) uut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgAdv(cfgAdv),
    .cfgMaster(cfgMaster), .cfgHiMask(cfgHiMask), .cfgLevel(cfgLevel),
    .clrWe(clrWe), .clrBits(clrBits), .sclkIn(sclkIn), .sdIn(sdIn),
    .rdyNIn(rdyNIn), .sclkOut(sclkOut), .rdyNOut(rdyNOut), .rdEn(rdEn),
    .rdData(rdData), .fillCount(fillCount), .intFlag(intFlag), .overrun(overrun)
  );

  always #5 clk = ~clk;

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    rstN = 1'b0; cfgWe = 0; clrWe = 0; rdEn = 0; sclkIn = 0; sdIn = 0; rdyNIn = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic writeCfg(logic adv, logic mst, logic mask, logic [1:0] lvl);
    cfgAdv = adv; cfgMaster = mst; cfgHiMask = mask; cfgLevel = lvl; cfgWe = 1'b1;
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic clearFlags(logic [1:0] bits);
    clrBits = bits; clrWe = 1'b1;
    @(negedge clk);
    clrWe = 1'b0;
  endtask

  task automatic popWord(output logic [7:0] d);
    d = rdData; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic slaveByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdIn = b[i]; sclkIn = 1'b0;
      repeat (2) @(negedge clk);
      sclkIn = 1'b1;
      repeat (2) @(negedge clk);
    end
  endtask

  task automatic masterByte(logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sdIn = b[i];
      @(posedge sclkOut);
      #1;
    end
    @(negedge clk);
  endtask

  task automatic t_reset();
    doReset();
    check("R1", "fillCount", fillCount, 0);
    check("R1", "intFlag", intFlag, 0);
    check("R1", "overrun", overrun, 0);
    check("R1", "rdyNOut", rdyNOut, 0);
    check("R1", "sclkOut", sclkOut, 0);
  endtask

  task automatic t_slaveBasic();
    logic [7:0] d;
    doReset();
    slaveByte(8'hA5);
    check("R2", "fillCount after one word", fillCount, 1);
    check("R2", "rdData msb-first", rdData, 8'hA5);
    check("R4", "intFlag at default threshold 1", intFlag, 1);
    popWord(d);
    check("R3", "fillCount after pop", fillCount, 0);
    popWord(d);
    check("R3", "pop on empty ignored", fillCount, 0);
    clearFlags(2'b01);
    check("R5", "intFlag cleared", intFlag, 0);
  endtask

  task automatic t_levels();
    doReset();
    writeCfg(1'b1, 1'b0, 1'b0, 2'd2);
    slaveByte(8'h01);
    slaveByte(8'h02);
    check("R4", "intFlag below threshold 3", intFlag, 0);
    slaveByte(8'h03);
    check("R4", "intFlag at threshold 3", intFlag, 1);
    clearFlags(2'b01);
    check("R5", "intFlag cleared by bit 0", intFlag, 0);
    slaveByte(8'h04);
    check("R4", "no set past threshold", intFlag, 0);
    check("R4", "fillCount four", fillCount, 4);
  endtask

  task automatic t_protect();
    doReset();
    writeCfg(1'b0, 1'b0, 1'b1, 2'd3);
    slaveByte(8'h10);
    check("R10", "level write ignored without adv", intFlag, 1);
    slaveByte(8'h20); slaveByte(8'h30); slaveByte(8'h40);
    check("R10", "mask write ignored without adv", rdyNOut, 0);
    writeCfg(1'b1, 1'b0, 1'b1, 2'd3);
    check("R10", "mask write taken with adv", rdyNOut, 1);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    doReset();
    slaveByte(8'h11); slaveByte(8'h22); slaveByte(8'h33); slaveByte(8'h44);
    check("R6", "rdyNOut stays ready when full", rdyNOut, 0);
    check("R6", "overrun before fifth", overrun, 0);
    slaveByte(8'h55);
    check("R6", "overrun after fifth", overrun, 1);
    check("R6", "fillCount stays 4", fillCount, 4);
    clearFlags(2'b01);
    check("R5", "bit 0 leaves overrun", overrun, 1);
    clearFlags(2'b10);
    check("R5", "overrun cleared by bit 1", overrun, 0);
    popWord(d); check("R2", "order word 1", d, 8'h11);
    popWord(d); check("R2", "order word 2", d, 8'h22);
    popWord(d); check("R2", "order word 3", d, 8'h33);
    popWord(d); check("R6", "fifth word discarded", d, 8'h44);
    check("R3", "drained", fillCount, 0);
  endtask

  task automatic t_slaveMask();
    logic [7:0] d;
    doReset();
    writeCfg(1'b1, 1'b0, 1'b1, 2'd0);
    slaveByte(8'h5A); slaveByte(8'hC3); slaveByte(8'h0F);
    check("R11", "rdyNOut ready while not full", rdyNOut, 0);
    check("R11", "reception unaffected", fillCount, 3);
    check("R11", "data unaffected", rdData, 8'h5A);
    slaveByte(8'hF0);
    check("R7", "rdyNOut high when full", rdyNOut, 1);
    popWord(d);
    check("R7", "rdyNOut released after read", rdyNOut, 0);
    check("R7", "count after read", fillCount, 3);
  endtask

  task automatic t_masterReady();
    logic [7:0] d;
    int rises = 0;
    int hiLen = 0;
    doReset();
    rdyNIn = 1'b1;
    writeCfg(1'b0, 1'b1, 1'b0, 2'd0);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (sclkOut) rises++;
    end
    check("R8", "no clock while remote not ready", rises, 0);
    rdyNIn = 1'b0;
    masterByte(8'h3C);
    check("R8", "word received as master", fillCount, 1);
    check("R8", "master data", rdData, 8'h3C);
    while (sclkOut) @(negedge clk);
    while (!sclkOut) @(negedge clk);
    while (sclkOut) begin hiLen++; @(negedge clk); end
    check("R8", "high phase length", hiLen, HALF);
    popWord(d);
  endtask

  task automatic t_masterMask();
    logic [7:0] d;
    int rises = 0;
    int seen = 0;
    doReset();
    rdyNIn = 1'b0;
    writeCfg(1'b1, 1'b1, 1'b1, 2'd3);
    masterByte(8'h81); masterByte(8'h42); masterByte(8'h24); masterByte(8'h18);
    check("R9", "full as master", fillCount, 4);
    check("R4", "intFlag at threshold 4", intFlag, 1);
    repeat (2 * HALF + 2) @(negedge clk);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclkOut) rises++;
    end
    check("R9", "clock held while full", rises, 0);
    check("R9", "no overrun under back-pressure", overrun, 0);
    popWord(d);
    check("R9", "first master word", d, 8'h81);
    for (int i = 0; i < 2 * HALF + 4; i++) begin
      if (sclkOut) seen = 1;
      @(negedge clk);
    end
    check("R9", "clock resumes after read", seen, 1);
  endtask

  initial begin
    t_reset();
    t_slaveBasic();
    t_levels();
    t_protect();
    t_overrun();
    t_slaveMask();
    t_masterReady();
    t_masterMask();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule